// File: doc/BRIEF.md
# Triggered Pipeline Column Controller

This block sequences the column addresses of a circular sample memory that takes one new column per clock cycle. A write pointer steps through the columns without stopping and wraps back to column 0. A trigger pointer trails the write pointer by a programmable latency. A trigger marks the column it addresses as reserved. In deconvolution mode it also reserves the two columns written just before that one. Each reserved column address goes into an in-order queue. The readout side takes addresses from the queue one at a time through a request/done handshake. A column becomes writable again once readout reports that it is done with it.

Reserved columns are protected while they wait. When the write pointer reaches a reserved column it still advances, but the memory write strobe stays low. Two conditions drop a trigger and raise a one-cycle error pulse. The first is a trigger that would land on an already reserved column, or on the column being written this cycle. The second is a trigger whose columns do not fit in the queue.

The readout side is a two-state machine. In RD_IDLE no address is presented. The transition RD_IDLE to RD_HOLD is taken on a request while the queue holds an entry, and it pops that entry. In RD_HOLD the address is presented with a valid flag. A done strobe frees the column. With no simultaneous request, or with an empty queue, the machine goes from RD_HOLD back to RD_IDLE. With a request and a non-empty queue it takes RD_HOLD to RD_HOLD and pops the next address at once.

Top module: `colctl_top`

## Requirements
- R1: After reset, `wr_col` is 0. It increments by one every clock cycle and wraps from 191 to 0.
- R2: A trigger sampled while the write pointer is W targets column (W − L) mod 192, where L is `latency`. A `latency` above 160 acts as 160.
- R3: With `decon_mode` = 0 (peak), an accepted trigger reserves and queues exactly one column: the target.
- R4: With `decon_mode` = 1 (deconvolution), an accepted trigger reserves the target T and the columns T−2 and T−1 (mod 192). All three are queued, oldest first: T−2, T−1, T.
- R5: While a column is reserved, `wr_en` is 0 in the cycles where `wr_col` equals that column. Once the column is released, `wr_en` is 1 there again.
- R6: Peak-mode triggers on consecutive cycles reserve consecutive columns. Each one is read out separately, in trigger order.
- R7: The queue holds 32 column addresses, which is room for 10 deconvolution events. A trigger whose columns would take the count above 32 is dropped, and `err_overflow` is 1 for the cycle after it.
- R8: A trigger is dropped with `err_latency` = 1 for the following cycle if any column it would reserve is already reserved, or if its target equals the column being written (latency 0). This error takes priority over an overflow, so at most one error flag is high.
- R9: A `rd_req` in RD_IDLE with a non-empty queue makes `rd_valid` 1 on the next cycle, with `rd_col` set to the oldest queued address. Both hold until `rd_done`. A `rd_req` with an empty queue leaves `rd_valid` at 0.
- R10: The clock edge that samples `rd_done` in RD_HOLD frees the column. `rd_valid` is 0 on the next cycle unless `rd_req` was also high and the queue was non-empty, in which case the next address is valid straight away. `rd_done` outside RD_HOLD has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one column per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| decon_mode | input | 1 | 0: peak (one column per trigger), 1: deconvolution (three columns) |
| latency | input | 8 | Distance from write pointer to trigger pointer, in cycles |
| trig | input | 1 | Trigger strobe, one per cycle at most |
| rd_req | input | 1 | Readout asks for the next queued column |
| rd_done | input | 1 | Readout has finished the presented column |
| rd_valid | output | 1 | `rd_col` holds a column handed to readout |
| rd_col | output | 8 | Column address being read out |
| wr_en | output | 1 | Memory write strobe for `wr_col` |
| wr_col | output | 8 | Column index being written this cycle |
| err_latency | output | 1 | One-cycle pulse: trigger dropped on a reserved or live column |
| err_overflow | output | 1 | One-cycle pulse: trigger dropped for lack of queue space |

## Verification
The handshake assertions assume that readout raises `rd_done` only while `rd_valid` is high. They also assume that `decon_mode` and `latency` are stable in the cycle a trigger is sampled. The bench drives done strobes only on cycles where it has just seen a valid address, and it changes mode and latency only together with the trigger strobe, at the falling edge. Deconvolution triggers in the capacity test are kept three cycles apart, so that only the deliberate overlap case reaches an already reserved column.

// File: rtl/colctl_pkg.sv
package colctl_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/colctl_wptr.sv
module colctl_wptr #(
    parameter int NCOL    = 192,
    parameter int MAX_LAT = 160,
    localparam int COLW   = $clog2(NCOL),
    localparam int LATW   = $clog2(MAX_LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LATW-1:0] latency,
    output logic [COLW-1:0] wr_ptr,
    output logic [COLW-1:0] tcol0,
    output logic [COLW-1:0] tcol1,
    output logic [COLW-1:0] tcol2
);
    localparam logic [COLW:0]   NCOL_X = (COLW + 1)'(NCOL);
    localparam logic [COLW-1:0] LAST   = COLW'(NCOL - 1);
    localparam logic [LATW-1:0] LAT_CAP = LATW'(MAX_LAT);

    logic [LATW-1:0] lat_eff;

    function automatic logic [COLW-1:0] back(input logic [COLW-1:0] c,
                                             input logic [COLW:0]   d);
        logic [COLW:0] s;
        s = {1'b0, c} + NCOL_X - d;
        if (s >= NCOL_X) s = s - NCOL_X;
        return s[COLW-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wr_ptr <= '0;
        else if (wr_ptr == LAST) wr_ptr <= '0;
        else                     wr_ptr <= wr_ptr + 1'b1;
    end

    always_comb begin
        lat_eff = (latency > LAT_CAP) ? LAT_CAP : latency;
        tcol0   = back(wr_ptr, (COLW + 1)'(lat_eff));
        tcol1   = back(tcol0, (COLW + 1)'(1));
        tcol2   = back(tcol0, (COLW + 1)'(2));
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr == LAST |=> wr_ptr == '0);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr != LAST |=> wr_ptr == $past(wr_ptr) + 1'b1);
endmodule

// File: rtl/colctl_resv.sv
module colctl_resv #(
    parameter int NCOL = 192
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOL-1:0] set_mask,
    input  logic [NCOL-1:0] clr_mask,
    output logic [NCOL-1:0] resv
);
    for (genvar i = 0; i < NCOL; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           resv[i] <= 1'b0;
            else if (set_mask[i]) resv[i] <= 1'b1;
            else if (clr_mask[i]) resv[i] <= 1'b0;
        end

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(resv[i]) |-> $past(clr_mask[i]));
    end
endmodule

// File: rtl/colctl_fifo.sv
module colctl_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int QCW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     push_n,
    input  logic [W-1:0]   d0,
    input  logic [W-1:0]   d1,
    input  logic [W-1:0]   d2,
    input  logic           pop,
    output logic [W-1:0]   head,
    output logic [QCW-1:0] count
);
    localparam logic [QCW-1:0] FULL = QCW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  din [3];
    logic [PW-1:0] wp, rp;

    always_comb begin
        din[0] = d0;
        din[1] = d1;
        din[2] = d2;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (push_n > 2'(i)) mem[wp + PW'(i)] <= din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PW'(push_n);
            rp    <= rp + PW'(pop);
            count <= count + QCW'(push_n) - QCW'(pop);
        end
    end

    assign head = mem[rp];

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    p_push_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_n != 2'd0 |-> (count + QCW'(push_n)) <= FULL);
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/colctl_top.sv
module colctl_top #(
    parameter int NCOL    = 192,
    parameter int MAX_LAT = 160,
    parameter int QDEPTH  = 32,
    localparam int COLW   = $clog2(NCOL),
    localparam int LATW   = $clog2(MAX_LAT + 1),
    localparam int QCW    = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            decon_mode,
    input  logic [LATW-1:0] latency,
    input  logic            trig,
    input  logic            rd_req,
    input  logic            rd_done,
    output logic            rd_valid,
    output logic [COLW-1:0] rd_col,
    output logic            wr_en,
    output logic [COLW-1:0] wr_col,
    output logic            err_latency,
    output logic            err_overflow
);
    import colctl_pkg::*;

    localparam logic [QCW-1:0] QFULL = QCW'(QDEPTH);

    logic [COLW-1:0] wr_ptr, tcol0, tcol1, tcol2;
    logic [NCOL-1:0] resv, set_mask, clr_mask;
    logic [1:0]      push_n;
    logic [COLW-1:0] d0, d1, d2, head;
    logic [QCW-1:0]  count, need;
    logic            lat_hit, full_hit, accept, pop, rel_now;
    logic [COLW-1:0] col_q;
    rd_state_e       state, state_nx;

    colctl_wptr #(.NCOL(NCOL), .MAX_LAT(MAX_LAT)) u_wptr (
        .clk(clk), .rst_n(rst_n), .latency(latency),
        .wr_ptr(wr_ptr), .tcol0(tcol0), .tcol1(tcol1), .tcol2(tcol2)
    );

    colctl_resv #(.NCOL(NCOL)) u_resv (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
        .clr_mask(clr_mask), .resv(resv)
    );

    colctl_fifo #(.DEPTH(QDEPTH), .W(COLW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(push_n),
        .d0(d0), .d1(d1), .d2(d2), .pop(pop),
        .head(head), .count(count)
    );

    // Trigger acceptance: latency conflict first, then queue space
    always_comb begin
        need     = decon_mode ? QCW'(3) : QCW'(1);
        lat_hit  = resv[tcol0] || (tcol0 == wr_ptr) ||
                   (decon_mode && (resv[tcol1] || resv[tcol2]));
        full_hit = (count + need) > QFULL;
        accept   = trig && !lat_hit && !full_hit;

        set_mask = '0;
        push_n   = 2'd0;
        d0       = tcol0;
        d1       = tcol1;
        d2       = tcol0;
        if (accept) begin
            set_mask[tcol0] = 1'b1;
            if (decon_mode) begin
                set_mask[tcol1] = 1'b1;
                set_mask[tcol2] = 1'b1;
                push_n = 2'd3;
                d0     = tcol2;
            end else begin
                push_n = 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_latency  <= 1'b0;
            err_overflow <= 1'b0;
        end else begin
            err_latency  <= trig && lat_hit;
            err_overflow <= trig && !lat_hit && full_hit;
        end
    end

    // Readout state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            col_q <= '0;
        end else begin
            state <= state_nx;
            if (pop) col_q <= head;
        end
    end

    // Readout state machine: transitions
    always_comb begin
        pop      = rd_req && (count != '0) && (state == RD_IDLE || rd_done);
        state_nx = state;
        unique case (state)
            RD_IDLE: if (pop)     state_nx = RD_HOLD;
            RD_HOLD: if (rd_done) state_nx = pop ? RD_HOLD : RD_IDLE;
        endcase
    end

    // Readout state machine: outputs
    always_comb begin
        rd_valid = (state == RD_HOLD);
        rd_col   = col_q;
        rel_now  = (state == RD_HOLD) && rd_done;
        clr_mask = '0;
        if (rel_now) clr_mask[col_q] = 1'b1;
    end

    assign wr_col = wr_ptr;
    assign wr_en  = !resv[wr_ptr];

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_latency, err_overflow}));
    p_lat_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig && latency == '0 |=> err_latency);
    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(trig));
    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_done |=> rd_valid && $stable(rd_col));
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_done && !rd_req |=> !rd_valid);
endmodule

// File: tb/sim_colctl_top.sv
module sim_colctl_top;
    localparam int NCOL = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       decon_mode = 1'b0;
    logic [7:0] latency = 8'd0;
    logic       trig = 1'b0, rd_req = 1'b0, rd_done = 1'b0;
    logic       rd_valid, wr_en, err_latency, err_overflow;
    logic [7:0] rd_col, wr_col;

    int checks = 0;
    int fails  = 0;
    int bptr   = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    colctl_top u0 (
        .clk(clk), .rst_n(rst_n), .decon_mode(decon_mode), .latency(latency),
        .trig(trig), .rd_req(rd_req), .rd_done(rd_done),
        .rd_valid(rd_valid), .rd_col(rd_col), .wr_en(wr_en), .wr_col(wr_col),
        .err_latency(err_latency), .err_overflow(err_overflow)
    );

    // Independent model of the write pointer (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) bptr <= 0;
        else        bptr <= (bptr + 1) % NCOL;
    end

    typedef struct packed {
        logic       dc;
        logic [7:0] lat;
        logic       err;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 8'd10,  1'b0},
        '{1'b1, 8'd20,  1'b0},
        '{1'b0, 8'd160, 1'b0},
        '{1'b1, 8'd0,   1'b1},
        '{1'b0, 8'd200, 1'b0},
        '{1'b1, 8'd1,   1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int target(input int lat);
        int eff = (lat > 160) ? 160 : lat;
        return (bptr + NCOL - eff) % NCOL;
    endfunction

    task automatic fire(input bit dc, input int lat, output int tp);
        decon_mode = dc;
        latency    = 8'(lat);
        trig       = 1'b1;
        tp         = target(lat);
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic read_seq(input int first, input int n, input string req);
        int bad = 0, ac = 0, ex = 0;
        rd_req = 1'b1;
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            if (!(rd_valid && int'(rd_col) == (first + k) % NCOL)) begin
                if (bad == 0) begin
                    ac = rd_valid ? int'(rd_col) : -1;
                    ex = (first + k) % NCOL;
                end
                bad++;
            end
            rd_done = 1'b1;
            rd_req  = (k < n - 1);
            @(negedge clk);
        end
        rd_done = 1'b0;
        rd_req  = 1'b0;
        check(bad == 0, req, ac, ex);
        check(!rd_valid, "R10 valid drops after done", int'(rd_valid), 0);
    endtask

    task automatic empty_req(input string req);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(!rd_valid, req, int'(rd_valid), 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #3_000_000;
        checks++;
        fails++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int tp, tp0, bad;
        repeat (3) @(negedge clk);
        // Reset state
        check(wr_col == 8'd0 && wr_en, "R1 reset column", int'(wr_col), 0);
        check(!rd_valid && !err_latency && !err_overflow, "R9 reset outputs",
              int'({rd_valid, err_latency, err_overflow}), 0);
        rst_n = 1'b1;

        // R1: stepping and wrap
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (int'(wr_col) != bptr || !wr_en) bad++;
        end
        check(bad == 0, "R1 pointer steps and wraps", bad, 0);

        // Table of trigger vectors (R2, R3, R4, R8)
        for (int v = 0; v < 6; v++) begin
            fire(VECS[v].dc, int'(VECS[v].lat), tp);
            check(err_latency == VECS[v].err, "R8 latency flag", int'(err_latency), int'(VECS[v].err));
            if (VECS[v].err) empty_req("R8 dropped trigger queues nothing");
            else if (VECS[v].dc) read_seq((tp + NCOL - 2) % NCOL, 3, "R4 triplet oldest first");
            else read_seq(tp, 1, "R2 R3 single target column");
        end

        // R6: consecutive peak triggers, back-to-back readout
        decon_mode = 1'b0;
        latency    = 8'd30;
        tp0        = target(30);
        trig       = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        check(!err_latency && !err_overflow, "R6 no error", int'(err_latency), 0);
        read_seq(tp0, 3, "R6 consecutive columns in order");
        empty_req("R9 request on empty queue");

        // R8: overlapping deconvolution triggers
        fire(1'b1, 40, tp0);
        check(!err_latency, "R8 first triplet accepted", int'(err_latency), 0);
        fire(1'b1, 40, tp);
        check(err_latency && !err_overflow, "R8 overlap rejected", int'(err_latency), 1);
        read_seq((tp0 + NCOL - 2) % NCOL, 3, "R8 only first triplet queued");
        empty_req("R8 overlap left no entries");

        // R5: write suppression on a reserved column
        fire(1'b0, 5, tp);
        for (int g = 0; g < 400 && bptr != tp; g++) @(negedge clk);
        check(!wr_en && int'(wr_col) == tp, "R5 write blocked", int'(wr_en), 0);
        @(negedge clk);
        check(wr_en, "R5 neighbour written", int'(wr_en), 1);
        read_seq(tp, 1, "R5 reserved column read");
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        check(!rd_valid, "R10 stray done ignored", int'(rd_valid), 0);
        for (int g = 0; g < 400 && bptr != tp; g++) @(negedge clk);
        check(wr_en && int'(wr_col) == tp, "R5 released column written", int'(wr_en), 1);

        // R7: peak overflow on the 33rd trigger
        decon_mode = 1'b0;
        latency    = 8'd50;
        tp0        = target(50);
        bad        = 0;
        trig       = 1'b1;
        for (int i = 0; i < 33; i++) begin
            @(negedge clk);
            if (err_overflow != (i == 32) || err_latency) bad++;
        end
        trig = 1'b0;
        check(bad == 0, "R7 overflow only on 33rd trigger", bad, 0);
        read_seq(tp0, 32, "R7 32 entries kept");
        empty_req("R7 dropped trigger not queued");

        // R7: ten deconvolution events fit, the eleventh overflows
        decon_mode = 1'b1;
        latency    = 8'd60;
        tp0        = target(60);
        bad        = 0;
        for (int j = 0; j < 11; j++) begin
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            if (err_overflow != (j == 10) || err_latency) bad++;
            repeat (2) @(negedge clk);
        end
        check(bad == 0, "R7 eleventh deconvolution event overflows", bad, 0);
        read_seq((tp0 + NCOL - 2) % NCOL, 30, "R4 R7 ten triplets in order");
        empty_req("R7 queue drained");

        finish_run();
    end
endmodule